// File: doc/BRIEF.md
# Capture Trigger Unit

This block decides the moment at which a data capture starts. On every sample clock it sees one 8-bit word of logic channels and one 10-bit converter sample. When a trigger condition holds, it produces a trigger pulse that lasts one cycle. The trigger condition is one of four kinds:

- an analog level crossing;
- a crossing pulse that is shorter than a width limit;
- a crossing pulse that is at least as long as the width limit;
- a masked match of the logic channels against a pattern.

A trigger can only occur while the unit is enabled through its configuration byte and the arm input is high. After each trigger a holdoff count of samples keeps the unit quiet.

The configuration byte carries four things: the enable, the edge polarity, the mode, and the two upper bits of the threshold. The lower eight threshold bits come from a separate byte. The holdoff is a 16-bit count, written as a high byte and a low byte. The width limit is given in sample periods. Raising the arm input starts a fresh acquisition: it drops any holdoff still pending and any pulse measurement in progress.

Top module: `capture_trigger`

## Requirements
- R1: While `cfg[7]` is 0, `trig_out` is never asserted.
- R2: A trigger occurs only on samples where `arm` is high. The sample on which `arm` goes from low to high clears the holdoff count and any pulse measurement in progress.
- R3: The threshold is `{cfg[1:0], thr_lo}`. With `cfg[2]` = 0 a qualifying crossing is a sample at or above the threshold whose previous sample was below it.
- R4: With `cfg[2]` = 1 a qualifying crossing is a sample below the threshold whose previous sample was at or above it. The crossing in the other direction is the opposite crossing.
- R5: `cfg[6:5]` selects the mode: 0 = level, 1 = narrow pulse, 2 = wide pulse, 3 = logic pattern. In level mode the unit triggers on each qualifying crossing.
- R6: In logic-pattern mode the unit triggers on each sample where every channel whose `msk` bit is 0 equals the matching `pat` bit. Channels whose `msk` bit is 1 are ignored.
- R7: With `msk` all ones and a holdoff of zero, logic-pattern mode triggers on every sample while enabled and armed.
- R8: In narrow-pulse mode the pulse width is the number of samples from the qualifying crossing to the next opposite crossing. The unit triggers at that opposite crossing when the width is less than `wlim`.
- R9: In wide-pulse mode the unit triggers at the opposite crossing when the width is at or above `wlim`.
- R10: Let H be `{hold_hi, hold_lo}`. After a trigger, the next H samples cannot trigger, so the earliest following trigger is H+1 samples later.
- R11: `trig_out` is registered. It goes high in the cycle after the clock edge that takes in the triggering sample. It is 0 during and right after reset, and the first sample after reset cannot form a crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | High while the unit may trigger; a rising edge restarts the acquisition |
| cfg | input | 8 | Enable, mode, polarity and upper threshold bits |
| thr_lo | input | 8 | Lower threshold bits |
| pat | input | 8 | Logic pattern value |
| msk | input | 8 | Logic mask, 1 = ignore channel |
| hold_hi | input | 8 | Upper holdoff byte |
| hold_lo | input | 8 | Lower holdoff byte |
| wlim | input | 16 | Pulse width limit in samples |
| logic_in | input | 8 | Logic channel sample |
| adc_in | input | 10 | Converter sample |
| trig_out | output | 1 | One-cycle trigger pulse |

## Verification
The level-mode patterns use samples just below and exactly at the threshold, which separates `>=` from `>` in the comparison. Crossings in the non-selected direction confirm that the polarity bit really chooses the edge. The logic patterns vary only masked channels in some samples and only unmasked channels in others, so a reversed mask polarity produces a mismatch. The pulse patterns use widths of 1, 2 and 3 against a limit of 3, which separates the narrow and wide modes at the exact boundary. Holdoff and re-arm sequences show that triggers are blocked for exactly H samples and that raising `arm` clears the block.

// File: rtl/trg_pkg.sv
package trg_pkg;
    typedef enum logic [1:0] {
        MODE_LEVEL  = 2'd0,
        MODE_NARROW = 2'd1,
        MODE_WIDE   = 2'd2,
        MODE_LOGIC  = 2'd3
    } trg_mode_e;

    localparam int CFG_EN_BIT   = 7;
    localparam int CFG_FALL_BIT = 2;
    localparam int CFG_MODE_LO  = 5;
endpackage

// File: rtl/trg_level_det.sv
module trg_level_det #(
    parameter int AW = 10
) (
    input  logic [AW-1:0] prev,
    input  logic          prev_vld,
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] thr,
    input  logic          falling,
    output logic          qual_x,
    output logic          opp_x
);
    logic up_x;
    logic dn_x;

    always_comb begin
        up_x   = prev_vld && (prev < thr) && (cur >= thr);
        dn_x   = prev_vld && (prev >= thr) && (cur < thr);
        qual_x = falling ? dn_x : up_x;
        opp_x  = falling ? up_x : dn_x;
    end
endmodule

// File: rtl/trg_pattern_match.sv
module trg_pattern_match #(
    parameter int LW = 8
) (
    input  logic [LW-1:0] data,
    input  logic [LW-1:0] pat,
    input  logic [LW-1:0] msk,
    output logic          hit
);
    logic [LW-1:0] care_miss;

    for (genvar i = 0; i < LW; i++) begin : g_bit
        assign care_miss[i] = !msk[i] && (data[i] != pat[i]);
    end

    assign hit = (care_miss == '0);
endmodule

// File: rtl/capture_trigger.sv
module capture_trigger
    import trg_pkg::*;
#(
    parameter int LW = 8,
    parameter int AW = 10,
    parameter int HW = 16,
    parameter int WW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [7:0]        cfg,
    input  logic [AW-3:0]     thr_lo,
    input  logic [LW-1:0]     pat,
    input  logic [LW-1:0]     msk,
    input  logic [HW/2-1:0]   hold_hi,
    input  logic [HW/2-1:0]   hold_lo,
    input  logic [WW-1:0]     wlim,
    input  logic [LW-1:0]     logic_in,
    input  logic [AW-1:0]     adc_in,
    output logic              trig_out
);
    localparam logic [WW-1:0] WMAX = {WW{1'b1}};

    typedef struct packed {
        logic [AW-1:0] prev;
        logic          prev_vld;
        logic          arm;
        logic          in_pulse;
        logic [WW-1:0] wcnt;
        logic [HW-1:0] hold;
        logic          trig;
    } state_t;

    state_t s_q, s_d;

    logic [AW-1:0] thr;
    logic          qual_x;
    logic          opp_x;
    logic          pat_hit;
    logic          arm_rise;
    logic          pulse_eff;
    logic [WW-1:0] wcnt_eff;
    logic [HW-1:0] hold_eff;
    logic [WW-1:0] wnow;
    logic          cand;
    logic          fire;
    trg_mode_e     mode;

    assign thr  = {cfg[1:0], thr_lo};
    assign mode = trg_mode_e'(cfg[CFG_MODE_LO+1:CFG_MODE_LO]);

    trg_level_det #(.AW(AW)) u_lvl (
        .prev     (s_q.prev),
        .prev_vld (s_q.prev_vld),
        .cur      (adc_in),
        .thr      (thr),
        .falling  (cfg[CFG_FALL_BIT]),
        .qual_x   (qual_x),
        .opp_x    (opp_x)
    );

    trg_pattern_match #(.LW(LW)) u_pat (
        .data (logic_in),
        .pat  (pat),
        .msk  (msk),
        .hit  (pat_hit)
    );

    always_comb begin
        arm_rise  = arm && !s_q.arm;
        pulse_eff = arm_rise ? 1'b0 : s_q.in_pulse;
        wcnt_eff  = arm_rise ? '0 : s_q.wcnt;
        hold_eff  = arm_rise ? '0 : s_q.hold;
        wnow      = (wcnt_eff == WMAX) ? WMAX : wcnt_eff + 1'b1;

        unique case (mode)
            MODE_LEVEL:  cand = qual_x;
            MODE_NARROW: cand = pulse_eff && opp_x && (wnow < wlim);
            MODE_WIDE:   cand = pulse_eff && opp_x && (wnow >= wlim);
            default:     cand = pat_hit;
        endcase

        fire = cfg[CFG_EN_BIT] && arm && (hold_eff == '0) && cand;

        s_d          = s_q;
        s_d.prev     = adc_in;
        s_d.prev_vld = 1'b1;
        s_d.arm      = arm;
        s_d.trig     = fire;

        if (qual_x) begin
            s_d.in_pulse = 1'b1;
            s_d.wcnt     = '0;
        end else if (opp_x) begin
            s_d.in_pulse = 1'b0;
            s_d.wcnt     = '0;
        end else if (pulse_eff) begin
            s_d.in_pulse = 1'b1;
            s_d.wcnt     = wnow;
        end else begin
            s_d.in_pulse = 1'b0;
            s_d.wcnt     = '0;
        end

        if (fire) begin
            s_d.hold = {hold_hi, hold_lo};
        end else if (hold_eff != '0) begin
            s_d.hold = hold_eff - 1'b1;
        end else begin
            s_d.hold = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign trig_out = s_q.trig;
endmodule

// File: rtl/trg_checker.sv
module trg_checker #(
    parameter int LW = 8,
    parameter int AW = 10,
    parameter int HW = 16,
    parameter int WW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic [7:0]        cfg,
    input logic [LW-1:0]     pat,
    input logic [LW-1:0]     msk,
    input logic [HW/2-1:0]   hold_hi,
    input logic [HW/2-1:0]   hold_lo,
    input logic [LW-1:0]     logic_in,
    input logic              trig_out
);
    // R1
    trig_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> $past(cfg[7]));

    // R2
    trig_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> $past(arm));

    // R6
    logic_mode_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && $past(cfg[6:5]) == 2'b11)
            |-> $past(((logic_in ^ pat) & ~msk) == '0));

    // R10
    holdoff_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && $past({hold_hi, hold_lo}) != '0) |=> !trig_out);
endmodule

bind capture_trigger trg_checker #(.LW(LW), .AW(AW), .HW(HW), .WW(WW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .cfg      (cfg),
    .pat      (pat),
    .msk      (msk),
    .hold_hi  (hold_hi),
    .hold_lo  (hold_lo),
    .logic_in (logic_in),
    .trig_out (trig_out)
);

// File: tb/sim_capture_trigger.sv
module sim_capture_trigger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic [7:0]  cfg = '0;
    logic [7:0]  thr_lo = '0;
    logic [7:0]  pat = '0;
    logic [7:0]  msk = '0;
    logic [7:0]  hold_hi = '0;
    logic [7:0]  hold_lo = '0;
    logic [15:0] wlim = '0;
    logic [7:0]  logic_in = '0;
    logic [9:0]  adc_in = '0;
    logic        trig_out;

    // values applied on the next step
    logic        n_arm = 1'b1;
    logic [7:0]  n_cfg = 8'h01;
    logic [7:0]  n_pat = '0;
    logic [7:0]  n_msk = '0;
    logic [7:0]  n_hold = '0;
    logic [15:0] n_wlim = 16'd3;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit    exp;
        string tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    capture_trigger u0 (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cfg(cfg), .thr_lo(thr_lo),
        .pat(pat), .msk(msk), .hold_hi(hold_hi), .hold_lo(hold_lo),
        .wlim(wlim), .logic_in(logic_in), .adc_in(adc_in), .trig_out(trig_out)
    );

    task automatic check(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: trig_out=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [9:0] a, input logic [7:0] l, input bit e, input string tag);
        item_t it;
        @(negedge clk);
        arm      = n_arm;
        cfg      = n_cfg;
        pat      = n_pat;
        msk      = n_msk;
        hold_lo  = n_hold;
        wlim     = n_wlim;
        adc_in   = a;
        logic_in = l;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(trig_out, it.exp, it.tag);
        end
    end

    initial begin
        thr_lo = 8'h53;
        repeat (3) @(negedge clk);
        check(trig_out, 1'b0, "R11 reset");
        rst_n = 1'b1;

        // threshold {01, 0x53} = 339; disabled
        n_cfg = 8'h01;
        step(10'd100, 8'h00, 0, "R11 first sample");
        step(10'd400, 8'h00, 0, "R1 disabled crossing");
        step(10'd100, 8'h00, 0, "R1 disabled");
        // enabled rising level
        n_cfg = 8'h81;
        step(10'd400, 8'h00, 1, "R3 rising crossing");
        step(10'd400, 8'h00, 0, "R3 no crossing");
        step(10'd338, 8'h00, 0, "R3 falling ignored");
        step(10'd339, 8'h00, 1, "R3 at threshold");
        // falling level
        n_cfg = 8'h85;
        step(10'd338, 8'h00, 1, "R4 falling crossing");
        step(10'd338, 8'h00, 0, "R4 steady");
        step(10'd500, 8'h00, 0, "R4 rising ignored");
        // arm gating
        n_cfg = 8'h81; n_arm = 1'b0;
        step(10'd100, 8'h00, 0, "R2 disarmed");
        step(10'd400, 8'h00, 0, "R2 disarmed crossing");
        n_arm = 1'b1;
        step(10'd100, 8'h00, 0, "R2 rearm");
        step(10'd400, 8'h00, 1, "R5 level mode after arm");
        // logic mode
        n_cfg = 8'hE0; n_pat = 8'hA5; n_msk = 8'h0F;
        step(10'd400, 8'hA0, 1, "R6 masked low nibble");
        step(10'd400, 8'h50, 0, "R6 unmasked mismatch");
        step(10'd400, 8'hAF, 1, "R6 masked differs");
        step(10'd400, 8'hB5, 0, "R6 one bit off");
        n_msk = 8'hFF;
        step(10'd400, 8'h00, 1, "R7 all ones mask a");
        step(10'd400, 8'h3C, 1, "R7 all ones mask b");
        step(10'd400, 8'hFF, 1, "R7 all ones mask c");
        // holdoff 3
        n_hold = 8'd3;
        step(10'd400, 8'h00, 1, "R10 first");
        step(10'd400, 8'h00, 0, "R10 block 1");
        step(10'd400, 8'h00, 0, "R10 block 2");
        step(10'd400, 8'h00, 0, "R10 block 3");
        step(10'd400, 8'h00, 1, "R10 after H");
        step(10'd400, 8'h00, 0, "R10 block again");
        n_arm = 1'b0;
        step(10'd400, 8'h00, 0, "R2 disarmed in holdoff");
        n_arm = 1'b1;
        step(10'd400, 8'h00, 1, "R2 rearm clears holdoff");
        n_hold = 8'd0;
        // narrow pulse, limit 3
        n_cfg = 8'hA1;
        step(10'd100, 8'h00, 0, "R8 opposite without pulse");
        step(10'd400, 8'h00, 0, "R8 start");
        step(10'd400, 8'h00, 0, "R8 inside");
        step(10'd100, 8'h00, 1, "R8 width 2 fires");
        step(10'd400, 8'h00, 0, "R8 start b");
        step(10'd400, 8'h00, 0, "R8 inside b1");
        step(10'd400, 8'h00, 0, "R8 inside b2");
        step(10'd100, 8'h00, 0, "R8 width 3 silent");
        // wide pulse
        n_cfg = 8'hC1;
        step(10'd400, 8'h00, 0, "R9 start");
        step(10'd400, 8'h00, 0, "R9 inside 1");
        step(10'd400, 8'h00, 0, "R9 inside 2");
        step(10'd100, 8'h00, 1, "R9 width 3 fires");
        step(10'd400, 8'h00, 0, "R9 start b");
        step(10'd100, 8'h00, 0, "R9 width 1 silent");
        // wide pulse on falling polarity
        n_cfg = 8'hC5;
        step(10'd400, 8'h00, 0, "R4 opposite first");
        step(10'd100, 8'h00, 0, "R4 falling start");
        step(10'd100, 8'h00, 0, "R9 low 1");
        step(10'd100, 8'h00, 0, "R9 low 2");
        step(10'd400, 8'h00, 1, "R9 falling width 3");
        step(10'd400, 8'h00, 0, "R9 idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule